// File: doc/BRIEF.md
# MII Receive Header Field Extractor

This block sits on the receive side of a 100 Mb/s media-independent interface. It takes the nibble stream and looks for the start-of-frame delimiter, discarding preamble nibbles until it finds one. It then counts every data nibble that follows. An eight-nibble shift window collects the stream. Each header field is copied out of that window on the nibble whose running count equals the field's last position. Each field is a fixed-position part of an untagged Ethernet header, an IPv4 header without options, and the leading part of a TCP, UDP or ICMP header. The block also keeps the system time seen when the frame began.

The parse runs in three stages. The link stage extracts nothing and only opens the network stage once the EtherType reads IPv4. The IPv4 protocol byte drives a demultiplexer that enables the transport extractors. A TCP frame enables both the port extractor, which is shared with UDP, and the TCP-only extractor. The feature record is offered when the frame ends, and only if every field its protocol needs has been captured.

The receive side cannot be stalled, so it has a nibble strobe and no ready. The record leaves through a valid/ready port. `out_valid` stays high and the record stays unchanged until `out_ready` is seen high at a clock edge. There is a single output slot. A record that completes while an earlier one is still unaccepted is discarded. If the consumer accepts the record in the same cycle that a new one completes, the new one is taken.

Top module: `mii_hdr_extract`

## Requirements
- R1: While hunting, the block accepts only nibbles taken with `rx_dv` and `rx_stb` both high. The delimiter is a 0x5 nibble followed directly by a 0xD nibble. A 0xD that does not follow a 0x5 is ignored, as are any number of 0x5 nibbles. Data nibble 0 is the nibble after the 0xD.
- R2: `out_ts` equals the `sys_time` value sampled at the clock edge that accepts the delimiter's 0xD nibble.
- R3: Data byte k is carried by data nibbles 2k (low half) and 2k+1 (high half). Multi-byte fields are most significant byte first. A record is produced only when bytes 12..13 read 0x0800.
- R4: `out_proto` is byte 23. `out_src_ip` is bytes 26..29 and `out_dst_ip` is bytes 30..33.
- R5: When the protocol is 6 (TCP), `out_src_port` is bytes 34..35, `out_dst_port` is bytes 36..37 and `out_tcp_flags` is byte 47. The frame needs at least 48 data bytes to produce a record.
- R6: When the protocol is 17 (UDP), the ports come from the same bytes as for TCP and `out_tcp_flags` is 0. At least 38 data bytes are needed.
- R7: When the protocol is 1 (ICMP), `out_src_port` carries bytes 34..35 (type and code), and both `out_dst_port` and `out_tcp_flags` are 0. At least 36 data bytes are needed. Any other protocol produces no record.
- R8: `out_len` is the number of data nibbles accepted before `rx_dv` fell. It saturates at 2^LEN_W-1.
- R9: `out_valid` rises on the clock edge that samples `rx_dv` low at the end of a complete frame. A frame that ends before its needed fields are captured produces no record. The nibble count and all field flags are cleared while `rx_dv` is low.
- R10: While `out_valid` is high and `out_ready` is low, the record holds steady. A record completing in that state is discarded.
- R11: Strobes taken while `rx_dv` is low, and cycles with `rx_stb` low, change neither the parse nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | TS_W | Free-running system time |
| rx_dv | input | 1 | Frame active (receive data valid) |
| rx_stb | input | 1 | Nibble strobe |
| rx_nib | input | 4 | Received nibble |
| out_ready | input | 1 | Consumer accepts record |
| out_valid | output | 1 | Record available |
| out_src_ip | output | 32 | IPv4 source address |
| out_dst_ip | output | 32 | IPv4 destination address |
| out_proto | output | 8 | IPv4 protocol |
| out_src_port | output | 16 | Source port, or ICMP type/code |
| out_dst_port | output | 16 | Destination port |
| out_tcp_flags | output | 8 | TCP flag byte |
| out_len | output | LEN_W | Data nibbles in the frame |
| out_ts | output | TS_W | Time at start of frame |

## Verification
Two results have fixed cycles. A record is due in the cycle straight after the edge that sees `rx_dv` low, and its timestamp equals the system time in the cycle the 0xD nibble was driven. The driver notes both of those cycle numbers as it drives each frame and queues them with the expected fields. The monitor checks the arrival cycle on the rising edge of `out_valid` and the contents on acceptance. For frames that must give no record, the bench samples `out_valid` in exactly the cycle a record would have arrived.

// File: rtl/mii_hx_pkg.sv
package mii_hx_pkg;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned WIN_NIB = 8;
  localparam int unsigned WIN_W   = NIB_W * WIN_NIB;

  // index of the last data nibble of each field (byte b ends at 2b+1)
  localparam int unsigned END_ETYPE = 27;
  localparam int unsigned END_PROTO = 47;
  localparam int unsigned END_SIP   = 59;
  localparam int unsigned END_DIP   = 67;
  localparam int unsigned END_SPORT = 71;
  localparam int unsigned END_DPORT = 75;
  localparam int unsigned END_FLAGS = 95;

  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  PR_ICMP    = 8'd1;
  localparam logic [7:0]  PR_TCP     = 8'd6;
  localparam logic [7:0]  PR_UDP     = 8'd17;

  localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;
  localparam logic [NIB_W-1:0] NIB_SFD = 4'hD;

  typedef enum logic [1:0] {FR_HUNT, FR_SAW5, FR_DATA} fr_state_t;

  typedef struct packed {
    logic [31:0] src_ip;
    logic [31:0] dst_ip;
    logic [7:0]  proto;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [7:0]  flags;
  } hdr_t;

  // bytes arrive low nibble first: swap nibble halves of every byte
  function automatic logic [WIN_W-1:0] nib_swap(input logic [WIN_W-1:0] w);
    logic [WIN_W-1:0] r;
    for (int b = 0; b < WIN_NIB / 2; b++)
      r[8*b +: 8] = {w[8*b +: 4], w[8*b+4 +: 4]};
    return r;
  endfunction
endpackage

// File: rtl/mii_hx_framer.sv
module mii_hx_framer
  import mii_hx_pkg::*;
#(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_dv,
  input  logic             rx_stb,
  input  logic [NIB_W-1:0] rx_nib,
  output logic             data_stb,
  output logic [LEN_W-1:0] idx,
  output logic             sof,
  output logic             eof,
  output logic             in_data
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  fr_state_t        st_q;
  logic [LEN_W-1:0] cnt_q;
  logic             take;

  assign take     = rx_dv && rx_stb;
  assign in_data  = (st_q == FR_DATA);
  assign data_stb = in_data && take;
  assign sof      = (st_q == FR_SAW5) && take && (rx_nib == NIB_SFD);
  assign eof      = in_data && !rx_dv;
  assign idx      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= FR_HUNT;
      cnt_q <= '0;
    end else if (!rx_dv) begin
      st_q  <= FR_HUNT;
      cnt_q <= '0;
    end else if (rx_stb) begin
      case (st_q)
        FR_HUNT: if (rx_nib == NIB_PRE) st_q <= FR_SAW5;
        FR_SAW5: begin
          if (rx_nib == NIB_SFD)      st_q <= FR_DATA;
          else if (rx_nib != NIB_PRE) st_q <= FR_HUNT;
        end
        default: if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  p_sof_enters_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (in_data && cnt_q == '0));
  p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |=> (!in_data && cnt_q == '0));
  p_no_strobe_no_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && !rx_stb) |=> ($stable(cnt_q) && $stable(st_q)));
endmodule

// File: rtl/mii_hx_field.sv
module mii_hx_field
  import mii_hx_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned LAST  = 27,
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             stb,
  input  logic [LEN_W-1:0] idx,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     q,
  output logic             v
);
  localparam logic [LEN_W-1:0] POS = LEN_W'(LAST);

  logic hit;
  assign hit = en && stb && (idx == POS);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      q <= '0;
      v <= 1'b0;
    end else if (hit) begin
      q <= din;
      v <= 1'b1;
    end
  end
endmodule

// File: rtl/mii_hx_fields.sv
module mii_hx_fields
  import mii_hx_pkg::*;
#(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb,
  input  logic [NIB_W-1:0] nib,
  input  logic [LEN_W-1:0] idx,
  output hdr_t             hdr,
  output logic             complete
);
  logic [WIN_W-1:0] win_q, win_nx, win_sw;
  assign win_nx = {win_q[WIN_W-NIB_W-1:0], nib};
  assign win_sw = nib_swap(win_nx);

  always_ff @(posedge clk) begin
    if (!rst_n)   win_q <= '0;
    else if (stb) win_q <= win_nx;
  end

  // link stage: only gates the network stage
  logic [15:0] etype_q;
  logic        etype_v, eth_ok;
  mii_hx_field #(.W(16), .LAST(END_ETYPE), .LEN_W(LEN_W)) u_etype (
    .clk, .rst_n, .clr, .en(1'b1), .stb, .idx, .din(win_sw[15:0]), .q(etype_q), .v(etype_v));
  assign eth_ok = etype_v && (etype_q == ETYPE_IPV4);

  // network stage
  logic [7:0]  proto_q;
  logic [31:0] sip_q, dip_q;
  logic        proto_v, sip_v, dip_v;
  mii_hx_field #(.W(8), .LAST(END_PROTO), .LEN_W(LEN_W)) u_proto (
    .clk, .rst_n, .clr, .en(eth_ok), .stb, .idx, .din(win_sw[7:0]), .q(proto_q), .v(proto_v));
  mii_hx_field #(.W(32), .LAST(END_SIP), .LEN_W(LEN_W)) u_sip (
    .clk, .rst_n, .clr, .en(eth_ok), .stb, .idx, .din(win_sw), .q(sip_q), .v(sip_v));
  mii_hx_field #(.W(32), .LAST(END_DIP), .LEN_W(LEN_W)) u_dip (
    .clk, .rst_n, .clr, .en(eth_ok), .stb, .idx, .din(win_sw), .q(dip_q), .v(dip_v));

  // transport demultiplexer: TCP also enables the shared port path
  logic en_tcp, en_udp, en_icmp;
  assign en_tcp  = proto_v && (proto_q == PR_TCP);
  assign en_udp  = proto_v && ((proto_q == PR_UDP) || (proto_q == PR_TCP));
  assign en_icmp = proto_v && (proto_q == PR_ICMP);

  logic [15:0] sport_q, dport_q, icmp_q;
  logic [7:0]  flags_q;
  logic        sport_v, dport_v, icmp_v, flags_v;
  mii_hx_field #(.W(16), .LAST(END_SPORT), .LEN_W(LEN_W)) u_sport (
    .clk, .rst_n, .clr, .en(en_udp), .stb, .idx, .din(win_sw[15:0]), .q(sport_q), .v(sport_v));
  mii_hx_field #(.W(16), .LAST(END_DPORT), .LEN_W(LEN_W)) u_dport (
    .clk, .rst_n, .clr, .en(en_udp), .stb, .idx, .din(win_sw[15:0]), .q(dport_q), .v(dport_v));
  mii_hx_field #(.W(16), .LAST(END_SPORT), .LEN_W(LEN_W)) u_icmp (
    .clk, .rst_n, .clr, .en(en_icmp), .stb, .idx, .din(win_sw[15:0]), .q(icmp_q), .v(icmp_v));
  mii_hx_field #(.W(8), .LAST(END_FLAGS), .LEN_W(LEN_W)) u_flags (
    .clk, .rst_n, .clr, .en(en_tcp), .stb, .idx, .din(win_sw[7:0]), .q(flags_q), .v(flags_v));

  logic ip_v, ports_v;
  assign ip_v    = sip_v && dip_v;
  assign ports_v = sport_v && dport_v;
  assign complete = ip_v && ((en_tcp && ports_v && flags_v) ||
                             (en_udp && !en_tcp && ports_v) ||
                             (en_icmp && icmp_v));

  assign hdr.src_ip = sip_q;
  assign hdr.dst_ip = dip_q;
  assign hdr.proto  = proto_q;
  assign hdr.sport  = en_icmp ? icmp_q : sport_q;
  assign hdr.dport  = dport_q;
  assign hdr.flags  = flags_q;

  p_clear_drops_complete_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !complete);
  p_tcp_uses_port_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_v && !clr) |-> (sport_v && dport_v));
  p_net_gated_by_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_v && !clr) |-> eth_ok);
endmodule

// File: rtl/mii_hx_outreg.sv
module mii_hx_outreg
  import mii_hx_pkg::*;
#(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  hdr_t             hdr_in,
  input  logic [TS_W-1:0]  ts_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             out_ready,
  output logic             out_valid,
  output hdr_t             hdr_q,
  output logic [TS_W-1:0]  ts_q,
  output logic [LEN_W-1:0] len_q
);
  logic load;
  assign load = load_req && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      hdr_q     <= '0;
      ts_q      <= '0;
      len_q     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      hdr_q     <= hdr_in;
      ts_q      <= ts_in;
      len_q     <= len_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(hdr_q) && $stable(ts_q) && $stable(len_q)));
endmodule

// File: rtl/mii_hdr_extract.sv
module mii_hdr_extract
  import mii_hx_pkg::*;
#(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  sys_time,
  input  logic             rx_dv,
  input  logic             rx_stb,
  input  logic [3:0]       rx_nib,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [31:0]      out_src_ip,
  output logic [31:0]      out_dst_ip,
  output logic [7:0]       out_proto,
  output logic [15:0]      out_src_port,
  output logic [15:0]      out_dst_port,
  output logic [7:0]       out_tcp_flags,
  output logic [LEN_W-1:0] out_len,
  output logic [TS_W-1:0]  out_ts
);
  logic             data_stb, sof, eof, in_data, complete;
  logic [LEN_W-1:0] idx;
  logic [TS_W-1:0]  ts_cap;
  hdr_t             hdr, hdr_o;

  mii_hx_framer #(.LEN_W(LEN_W)) u_framer (
    .clk, .rst_n, .rx_dv, .rx_stb, .rx_nib,
    .data_stb, .idx, .sof, .eof, .in_data);

  // timestamp stage: plain capture at start of frame
  always_ff @(posedge clk) begin
    if (!rst_n)   ts_cap <= '0;
    else if (sof) ts_cap <= sys_time;
  end

  mii_hx_fields #(.LEN_W(LEN_W)) u_fields (
    .clk, .rst_n, .clr(!in_data), .stb(data_stb), .nib(rx_nib), .idx,
    .hdr, .complete);

  mii_hx_outreg #(.TS_W(TS_W), .LEN_W(LEN_W)) u_out (
    .clk, .rst_n, .load_req(eof && complete), .hdr_in(hdr), .ts_in(ts_cap),
    .len_in(idx), .out_ready, .out_valid, .hdr_q(hdr_o), .ts_q(out_ts), .len_q(out_len));

  assign out_src_ip    = hdr_o.src_ip;
  assign out_dst_ip    = hdr_o.dst_ip;
  assign out_proto     = hdr_o.proto;
  assign out_src_port  = hdr_o.sport;
  assign out_dst_port  = hdr_o.dport;
  assign out_tcp_flags = hdr_o.flags;

  p_record_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(eof && complete));
  p_known_proto_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_proto == PR_TCP || out_proto == PR_UDP || out_proto == PR_ICMP));
endmodule

// File: tb/mii_hdr_extract_bench.sv
module mii_hdr_extract_bench;
  localparam int TS_W  = 32;
  localparam int LEN_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_dv = 1'b0, rx_stb = 1'b0, out_ready = 1'b1;
  logic [3:0] rx_nib = 4'h0;
  logic [TS_W-1:0] sys_time;
  logic out_valid;
  logic [31:0] out_src_ip, out_dst_ip;
  logic [7:0] out_proto, out_tcp_flags;
  logic [15:0] out_src_port, out_dst_port;
  logic [LEN_W-1:0] out_len;
  logic [TS_W-1:0] out_ts;

  int cyc = 0;
  int nchk = 0, nbad = 0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign sys_time = TS_W'(cyc);

  mii_hdr_extract #(.TS_W(TS_W), .LEN_W(LEN_W)) u_mii_hdr_extract (
    .clk, .rst_n, .sys_time, .rx_dv, .rx_stb, .rx_nib, .out_ready, .out_valid,
    .out_src_ip, .out_dst_ip, .out_proto, .out_src_port, .out_dst_port,
    .out_tcp_flags, .out_len, .out_ts);

  typedef struct {
    logic [31:0] sip, dip;
    logic [7:0]  proto, fl;
    logic [15:0] sp, dp;
    int len, ts, due;
  } exp_t;
  exp_t q[$];
  exp_t e;
  logic [7:0] fb [0:4199];
  bit pv = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // monitor: arrival cycle on rise, contents on acceptance
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !pv) begin
        if (q.size() == 0) chk(1'b0, "R9", "unexpected record", 1, 0);
        else chk(cyc == q[0].due, "R9", "arrival cycle", cyc, q[0].due);
      end
      if (out_valid && out_ready && q.size() != 0) begin
        e = q.pop_front();
        chk(out_src_ip == e.sip, "R4", "src ip", out_src_ip, e.sip);
        chk(out_dst_ip == e.dip, "R4", "dst ip", out_dst_ip, e.dip);
        chk(out_proto == e.proto, "R4", "proto", out_proto, e.proto);
        chk(out_src_port == e.sp, e.proto == 8'd1 ? "R7" : (e.proto == 8'd6 ? "R5" : "R6"),
            "src port", out_src_port, e.sp);
        chk(out_dst_port == e.dp, e.proto == 8'd1 ? "R7" : (e.proto == 8'd6 ? "R5" : "R6"),
            "dst port", out_dst_port, e.dp);
        chk(out_tcp_flags == e.fl, e.proto == 8'd6 ? "R5" : "R6", "flags", out_tcp_flags, e.fl);
        chk(int'(out_len) == e.len, "R8", "length", out_len, e.len);
        chk(int'(out_ts) == e.ts, "R2", "timestamp", out_ts, e.ts);
      end
    end
    pv = out_valid;
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      nchk++; nbad++;
      $display("FAIL watchdog R9: actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic put(input logic [3:0] v, input int gap, output int t);
    @(negedge clk);
    rx_dv = 1'b1; rx_stb = 1'b1; rx_nib = v; t = cyc;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      rx_stb = 1'b0; rx_nib = 4'hD;   // R11: strobe low, nibble ignored
    end
  endtask

  task automatic send(input int pre_n, input bit junk, input int nb, input int gap,
                      input bit push, input string nreq, input logic [15:0] etype,
                      input logic [7:0] proto, input logic [31:0] sip, input logic [31:0] dip,
                      input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] fl);
    int t, ts;
    bit rec;
    exp_t x;
    for (int i = 0; i < nb; i++) fb[i] = 8'(i * 13 + 7);
    fb[12] = etype[15:8]; fb[13] = etype[7:0];
    fb[14] = 8'h45; fb[23] = proto;
    for (int i = 0; i < 4; i++) begin
      fb[26+i] = sip[31-8*i -: 8];
      fb[30+i] = dip[31-8*i -: 8];
    end
    fb[34] = sp[15:8]; fb[35] = sp[7:0];
    fb[36] = dp[15:8]; fb[37] = dp[7:0];
    fb[47] = fl;
    if (junk) begin put(4'h0, 0, t); put(4'hD, 0, t); put(4'hA, 0, t); end
    for (int i = 0; i < pre_n; i++) put(4'h5, gap, t);
    put(4'hD, gap, ts);
    for (int i = 0; i < nb; i++) begin
      put(fb[i][3:0], gap, t);
      put(fb[i][7:4], gap, t);
    end
    @(negedge clk);
    rx_dv = 1'b0; rx_stb = 1'b0;
    rec = (etype == 16'h0800) && ((proto == 8'd6 && nb >= 48) ||
          (proto == 8'd17 && nb >= 38) || (proto == 8'd1 && nb >= 36));
    x.sip = sip; x.dip = dip; x.proto = proto; x.sp = sp;
    x.dp = (proto == 8'd1) ? 16'h0 : dp;
    x.fl = (proto == 8'd6) ? fl : 8'h0;
    x.len = (2 * nb > 4095) ? 4095 : 2 * nb;
    x.ts = ts; x.due = cyc + 1;
    if (rec && push) q.push_back(x);
    if (!rec) begin
      @(negedge clk);
      chk(out_valid == 1'b0, nreq, "no record expected", out_valid, 0);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "reset valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R4 R5: TCP, long preamble
    send(15, 0, 64, 0, 1, "R5", 16'h0800, 8'd6, 32'hC0A80101, 32'h0A000002,
         16'd443, 16'd51000, 8'h12);
    // R1 R6: junk before preamble (0xD not after 0x5), short preamble
    send(3, 1, 60, 0, 1, "R6", 16'h0800, 8'd17, 32'h11223344, 32'h55667788,
         16'd53, 16'd1234, 8'hFF);
    // R7: ICMP type/code
    send(7, 0, 50, 0, 1, "R7", 16'h0800, 8'd1, 32'hAC100001, 32'hAC1000FE,
         16'h0800, 16'hBEEF, 8'h3C);
    // R7: other protocol gives nothing
    send(7, 0, 64, 0, 1, "R7", 16'h0800, 8'd2, 32'h01020304, 32'h05060708,
         16'd1, 16'd2, 8'h01);
    // R3: non-IPv4 EtherType gives nothing
    send(7, 0, 64, 0, 1, "R3", 16'h86DD, 8'd6, 32'h01020304, 32'h05060708,
         16'd1, 16'd2, 8'h01);
    // R9: truncated TCP frame
    send(7, 0, 47, 0, 1, "R9", 16'h0800, 8'd6, 32'h0A0A0A0A, 32'h0B0B0B0B,
         16'd80, 16'd8080, 8'h18);
    // R5: TCP boundary, exactly 48 bytes
    send(7, 0, 48, 0, 1, "R5", 16'h0800, 8'd6, 32'hDEADBEEF, 32'hCAFEF00D,
         16'd22, 16'd60000, 8'h11);
    // R6 R11: gaps with strobe low between nibbles
    send(7, 0, 40, 2, 1, "R11", 16'h0800, 8'd17, 32'h7F000001, 32'h7F000002,
         16'd67, 16'd68, 8'h00);
    // R11: strobes with frame-active low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rx_dv = 1'b0; rx_stb = 1'b1; rx_nib = (i == 5) ? 4'hD : 4'h5;
    end
    @(negedge clk); rx_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11", "strobes with dv low", out_valid, 0);
    // R8: saturating length
    send(7, 0, 2100, 0, 1, "R8", 16'h0800, 8'd17, 32'h0, 32'hFFFFFFFF,
         16'd9, 16'd10, 8'h00);
    // R10: back-pressure, second record discarded
    out_ready = 1'b0;
    send(7, 0, 40, 0, 1, "R10", 16'h0800, 8'd17, 32'hA1A2A3A4, 32'hB1B2B3B4,
         16'd100, 16'd200, 8'h00);
    send(7, 0, 64, 0, 0, "R10", 16'h0800, 8'd6, 32'hE1E2E3E4, 32'hF1F2F3F4,
         16'd300, 16'd400, 8'h02);
    chk(out_valid == 1'b1, "R10", "held valid", out_valid, 1);
    chk(out_src_ip == 32'hA1A2A3A4, "R10", "held record", out_src_ip, 32'hA1A2A3A4);
    chk(out_proto == 8'd17, "R10", "held proto", out_proto, 17);
    out_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R9", "records outstanding", q.size(), 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule